// File: doc/BRIEF.md
# Programmable FIFO Level Interrupt Generator

This block turns the fill levels of a UART's receive and transmit FIFOs into the two data-flow interrupt requests: "receive data available" and "transmit buffer wants more data". In enhanced mode, both thresholds come from 7-bit trigger registers that software can set to any value. In legacy mode, each threshold comes from one of four fixed levels chosen by a 2-bit field. A zero transmit threshold has a special meaning: the transmit request then waits until the whole transmit path has gone quiet. That means the FIFO is empty, the shift register is empty and the serial line idles at the marking level.

The receive request follows the FIFO level directly. The transmit request is held in a pending flag that sets when the trigger condition becomes true. The flag is consumed when software reads the interrupt ID while it shows the transmit source, or when software writes to the transmit FIFO. A four-bit interrupt ID, prioritised between the two sources, is produced for the interrupt identification logic around the block.

Top module: `fifo_level_irq`

## Requirements
- R1: In enhanced mode (`enh_mode`=1) with a nonzero receive trigger, `rx_irq` is 1 exactly when `ie_rx` is 1 and `rx_level` is greater than or equal to `rx_trig_reg`.
- R2: A receive trigger register value of 0 acts as a threshold of 1, so an empty receive FIFO never raises `rx_irq`.
- R3: In enhanced mode with a nonzero transmit trigger, the transmit condition is true exactly when `tx_level` is less than `tx_trig_reg`.
- R4: In enhanced mode with `tx_trig_reg` = 0, the transmit condition is true only when `tx_level` is 0, `tx_shift_empty` is 1 and `tx_line_idle` is 1.
- R5: In legacy mode (`enh_mode`=0), `rx_legacy_sel` selects the receive threshold: 0 gives 1, 1 gives 32, 2 gives 64 and 3 gives 112. `rx_trig_reg` has no effect in this mode.
- R6: In legacy mode, `tx_legacy_sel` selects the transmit threshold: 0 gives 1, 1 gives 16, 2 gives 32 and 3 gives 64. The condition is `tx_level` below that threshold, and `tx_trig_reg` has no effect in this mode.
- R7: In enhanced mode, `rx_legacy_sel` and `tx_legacy_sel` have no effect on either request.
- R8: `rx_irq` is 0 whenever `ie_rx` is 0, and `tx_irq` is 0 whenever `ie_tx` is 0.
- R9: `irq_id` is 4'b0100 when `rx_irq` is 1, is 4'b0010 when only `tx_irq` is 1, and is 4'b0001 when neither is set. Receive takes priority.
- R10: The transmit pending flag sets at the clock edge where the transmit condition is true and was false on the previous cycle, so `tx_irq` rises one cycle after the condition rises. The flag clears at an edge with `tx_wr` = 1, at an edge with `id_rd` = 1 while `irq_id` is 4'b0010, or at an edge where the condition is false; a clear wins over a set at the same edge. After a clear, the flag is set again only on a new rise of the condition. `tx_irq` is 0 in any cycle where the condition is false.
- R11: During and directly after reset the transmit flag is clear, so `tx_irq` is 0 and, with an empty receive FIFO, `irq_id` is 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_level | input | 8 | Receive FIFO fill level |
| tx_level | input | 8 | Transmit FIFO fill level |
| tx_shift_empty | input | 1 | Transmit shift register holds no data |
| tx_line_idle | input | 1 | Serial output idles at marking level |
| rx_trig_reg | input | 7 | Programmable receive trigger |
| tx_trig_reg | input | 7 | Programmable transmit trigger |
| enh_mode | input | 1 | 1 selects the programmable triggers |
| rx_legacy_sel | input | 2 | Legacy receive trigger select |
| tx_legacy_sel | input | 2 | Legacy transmit trigger select |
| ie_rx | input | 1 | Receive interrupt enable |
| ie_tx | input | 1 | Transmit interrupt enable |
| id_rd | input | 1 | Pulse: interrupt ID is being read |
| tx_wr | input | 1 | Pulse: write into the transmit FIFO |
| rx_irq | output | 1 | Receive data available request |
| tx_irq | output | 1 | Transmit buffer request |
| irq_id | output | 4 | Prioritised interrupt ID |

## Verification
On every cycle, the assertions check that an empty receive FIFO never raises a request and that the enhanced receive threshold is honoured. They also check that a zero transmit trigger only reports a fully idle transmit path, that masking holds, that receive wins the ID, and that a write or ID read consumes the transmit request. Some behaviours only the bench's scenarios can show. These are the legacy threshold tables, the fact that the unused trigger source is ignored in each mode, the one-cycle delay on the transmit request, and the rule that a consumed request does not return until its condition falls and rises again. The bench covers these with directed edges and a long seeded random run against a reference model.

// File: rtl/fli_pkg.sv
// Package of shared constants and threshold tables for the FIFO level
// interrupt generator. Assumes triggers fit in 7 bits.
package fli_pkg;

    localparam logic [3:0] IID_NONE = 4'b0001;
    localparam logic [3:0] IID_RX   = 4'b0100;
    localparam logic [3:0] IID_TX   = 4'b0010;

    // Legacy receive threshold for a 2-bit select.
    function automatic logic [6:0] legacy_rx_thresh(input logic [1:0] sel);
        case (sel)
            2'd0:    return 7'd1;
            2'd1:    return 7'd32;
            2'd2:    return 7'd64;
            default: return 7'd112;
        endcase
    endfunction

    // Legacy transmit threshold for a 2-bit select.
    function automatic logic [6:0] legacy_tx_thresh(input logic [1:0] sel);
        case (sel)
            2'd0:    return 7'd1;
            2'd1:    return 7'd16;
            2'd2:    return 7'd32;
            default: return 7'd64;
        endcase
    endfunction

endpackage

// File: rtl/fli_trig_sel.sv
// Threshold selection. Picks the programmable or the legacy trigger for
// each direction and widens it to the FIFO level width. Assumes
// LEVEL_W > TRIG_W. A zero receive trigger is promoted to 1. A zero
// transmit trigger in enhanced mode is flagged as idle mode.
module fli_trig_sel #(
    parameter int LEVEL_W = 8,
    parameter int TRIG_W  = 7
) (
    input  logic               enh_mode,
    input  logic [TRIG_W-1:0]  rx_trig_reg,
    input  logic [TRIG_W-1:0]  tx_trig_reg,
    input  logic [1:0]         rx_legacy_sel,
    input  logic [1:0]         tx_legacy_sel,
    output logic [LEVEL_W-1:0] rx_thresh,
    output logic [LEVEL_W-1:0] tx_thresh,
    output logic               tx_idle_mode
);
    import fli_pkg::*;

    localparam int PAD = LEVEL_W - TRIG_W;

    logic [TRIG_W-1:0] rx_raw;
    logic [TRIG_W-1:0] tx_raw;

    // Choose the trigger source by mode.
    always_comb begin
        rx_raw = enh_mode ? rx_trig_reg : legacy_rx_thresh(rx_legacy_sel);
        tx_raw = enh_mode ? tx_trig_reg : legacy_tx_thresh(tx_legacy_sel);
    end

    // Widen, promote a zero receive trigger, and detect the idle mode.
    always_comb begin
        if (rx_raw == '0)
            rx_thresh = LEVEL_W'(1);
        else
            rx_thresh = {{PAD{1'b0}}, rx_raw};
        tx_thresh    = {{PAD{1'b0}}, tx_raw};
        tx_idle_mode = enh_mode && (tx_trig_reg == '0);
    end

endmodule

// File: rtl/fli_rx_detect.sv
// Receive level compare. Raises the receive request when the FIFO level
// has reached the threshold and the enable is set. Purely combinational.
module fli_rx_detect #(
    parameter int LEVEL_W = 8
) (
    input  logic [LEVEL_W-1:0] rx_level,
    input  logic [LEVEL_W-1:0] rx_thresh,
    input  logic               ie_rx,
    output logic               rx_irq
);
    // Compare the level against the threshold and apply the mask.
    always_comb begin
        rx_irq = ie_rx && (rx_level >= rx_thresh);
    end

endmodule

// File: rtl/fli_tx_arm.sv
// Transmit condition and pending flag. Evaluates the transmit condition,
// which is either "level below threshold" or, in idle mode, a fully quiet
// transmit path. Holds a flag that sets on a rise of the condition and is
// consumed by a FIFO write or an ID read of the transmit source. Assumes
// tx_wr and id_rd_tx are single-cycle pulses.
module fli_tx_arm #(
    parameter int LEVEL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LEVEL_W-1:0] tx_level,
    input  logic [LEVEL_W-1:0] tx_thresh,
    input  logic               tx_idle_mode,
    input  logic               tx_shift_empty,
    input  logic               tx_line_idle,
    input  logic               ie_tx,
    input  logic               tx_wr,
    input  logic               id_rd_tx,
    output logic               tx_irq
);
    logic cond;
    logic cond_q;
    logic pend_q;

    // Evaluate the transmit trigger condition.
    always_comb begin
        if (tx_idle_mode)
            cond = (tx_level == '0) && tx_shift_empty && tx_line_idle;
        else
            cond = tx_level < tx_thresh;
    end

    // Track the previous condition and update the pending flag; clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            cond_q <= cond;
            if (!cond)
                pend_q <= 1'b0;
            else if (tx_wr || id_rd_tx)
                pend_q <= 1'b0;
            else if (!cond_q)
                pend_q <= 1'b1;
        end
    end

    // Present the request only while the flag is set, the condition holds and the enable is set.
    always_comb begin
        tx_irq = ie_tx && pend_q && cond;
    end

    AST_TX_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |=> !pend_q); // R10

endmodule

// File: rtl/fli_id_enc.sv
// Interrupt ID encoder. Priority-encodes the two request lines, with
// receive above transmit.
module fli_id_enc (
    input  logic       rx_irq,
    input  logic       tx_irq,
    output logic [3:0] irq_id
);
    import fli_pkg::*;

    // Select the highest-priority pending source.
    always_comb begin
        if (rx_irq)
            irq_id = IID_RX;
        else if (tx_irq)
            irq_id = IID_TX;
        else
            irq_id = IID_NONE;
    end

endmodule

// File: rtl/fifo_level_irq.sv
// FIFO level interrupt generator, top level. Connects threshold selection,
// the receive compare, the transmit flag and the ID encoder. Assumes the
// FIFO levels are stable around the clock edge and LEVEL_W > TRIG_W.
module fifo_level_irq #(
    parameter int LEVEL_W = 8,
    parameter int TRIG_W  = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LEVEL_W-1:0] rx_level,
    input  logic [LEVEL_W-1:0] tx_level,
    input  logic               tx_shift_empty,
    input  logic               tx_line_idle,
    input  logic [TRIG_W-1:0]  rx_trig_reg,
    input  logic [TRIG_W-1:0]  tx_trig_reg,
    input  logic               enh_mode,
    input  logic [1:0]         rx_legacy_sel,
    input  logic [1:0]         tx_legacy_sel,
    input  logic               ie_rx,
    input  logic               ie_tx,
    input  logic               id_rd,
    input  logic               tx_wr,
    output logic               rx_irq,
    output logic               tx_irq,
    output logic [3:0]         irq_id
);
    import fli_pkg::*;

    logic [LEVEL_W-1:0] rx_thresh;
    logic [LEVEL_W-1:0] tx_thresh;
    logic               tx_idle_mode;
    logic               id_rd_tx;

    fli_trig_sel #(.LEVEL_W(LEVEL_W), .TRIG_W(TRIG_W)) u_trig_sel (
        .enh_mode      (enh_mode),
        .rx_trig_reg   (rx_trig_reg),
        .tx_trig_reg   (tx_trig_reg),
        .rx_legacy_sel (rx_legacy_sel),
        .tx_legacy_sel (tx_legacy_sel),
        .rx_thresh     (rx_thresh),
        .tx_thresh     (tx_thresh),
        .tx_idle_mode  (tx_idle_mode)
    );

    fli_rx_detect #(.LEVEL_W(LEVEL_W)) u_rx_detect (
        .rx_level  (rx_level),
        .rx_thresh (rx_thresh),
        .ie_rx     (ie_rx),
        .rx_irq    (rx_irq)
    );

    // An ID read consumes the transmit request only while it is the reported source.
    always_comb begin
        id_rd_tx = id_rd && (irq_id == IID_TX);
    end

    fli_tx_arm #(.LEVEL_W(LEVEL_W)) u_tx_arm (
        .clk            (clk),
        .rst_n          (rst_n),
        .tx_level       (tx_level),
        .tx_thresh      (tx_thresh),
        .tx_idle_mode   (tx_idle_mode),
        .tx_shift_empty (tx_shift_empty),
        .tx_line_idle   (tx_line_idle),
        .ie_tx          (ie_tx),
        .tx_wr          (tx_wr),
        .id_rd_tx       (id_rd_tx),
        .tx_irq         (tx_irq)
    );

    fli_id_enc u_id_enc (
        .rx_irq (rx_irq),
        .tx_irq (tx_irq),
        .irq_id (irq_id)
    );

    AST_ENH_RX_REACHED: assert property (@(posedge clk) disable iff (!rst_n)
        (enh_mode && ie_rx && rx_trig_reg != '0 &&
         rx_level >= {{(LEVEL_W-TRIG_W){1'b0}}, rx_trig_reg}) |-> rx_irq); // R1
    AST_RX_NEVER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (rx_level != '0)); // R2
    AST_TX_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (enh_mode && tx_trig_reg == '0 && tx_irq) |->
        (tx_level == '0 && tx_shift_empty && tx_line_idle)); // R4
    AST_TX_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !ie_tx |-> !tx_irq); // R8
    AST_RX_WINS_ID: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (irq_id == IID_RX)); // R9
    AST_TX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rd && irq_id == IID_TX) |=> !tx_irq); // R10

endmodule

// File: tb/fifo_level_irq_bench.sv
`timescale 1ns/1ps
module fifo_level_irq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_level = '0;
    logic [7:0] tx_level = 8'd5;
    logic       tx_shift_empty = 1'b0;
    logic       tx_line_idle = 1'b0;
    logic [6:0] rx_trig_reg = 7'd10;
    logic [6:0] tx_trig_reg = 7'd2;
    logic       enh_mode = 1'b1;
    logic [1:0] rx_legacy_sel = '0;
    logic [1:0] tx_legacy_sel = '0;
    logic       ie_rx = 1'b1;
    logic       ie_tx = 1'b1;
    logic       id_rd = 1'b0;
    logic       tx_wr = 1'b0;
    logic       rx_irq;
    logic       tx_irq;
    logic [3:0] irq_id;

    int  checks = 0;
    int  errors = 0;
    bit  m_pend = 1'b0;
    bit  m_cq = 1'b0;

    always #2 clk = ~clk;

    fifo_level_irq u_fifo_level_irq (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
        .tx_shift_empty(tx_shift_empty), .tx_line_idle(tx_line_idle),
        .rx_trig_reg(rx_trig_reg), .tx_trig_reg(tx_trig_reg),
        .enh_mode(enh_mode), .rx_legacy_sel(rx_legacy_sel),
        .tx_legacy_sel(tx_legacy_sel), .ie_rx(ie_rx), .ie_tx(ie_tx),
        .id_rd(id_rd), .tx_wr(tx_wr), .rx_irq(rx_irq), .tx_irq(tx_irq),
        .irq_id(irq_id)
    );

    // Receive threshold from the requirement tables.
    function automatic int exp_rx_thr();
        int t;
        if (enh_mode) t = int'(rx_trig_reg);
        else case (rx_legacy_sel)
            2'd0: t = 1; 2'd1: t = 32; 2'd2: t = 64; default: t = 112;
        endcase
        if (t == 0) t = 1;
        return t;
    endfunction

    function automatic bit exp_tx_cond();
        int t;
        if (enh_mode && tx_trig_reg == 0)
            return (tx_level == 0) && tx_shift_empty && tx_line_idle;
        if (enh_mode) t = int'(tx_trig_reg);
        else case (tx_legacy_sel)
            2'd0: t = 1; 2'd1: t = 16; 2'd2: t = 32; default: t = 64;
        endcase
        return int'(tx_level) < t;
    endfunction

    function automatic bit exp_rx();
        return ie_rx && (int'(rx_level) >= exp_rx_thr());
    endfunction

    function automatic bit exp_tx();
        return ie_tx && m_pend && exp_tx_cond();
    endfunction

    function automatic logic [3:0] exp_id();
        return exp_rx() ? 4'b0100 : (exp_tx() ? 4'b0010 : 4'b0001);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Compare all outputs with the model, then advance one clock.
    task automatic step(input string tag);
        #1;
        check(tag, "rx_irq", int'(rx_irq), int'(exp_rx()));
        check(tag, "tx_irq", int'(tx_irq), int'(exp_tx()));
        check(tag, "irq_id", int'(irq_id), int'(exp_id()));
        @(posedge clk);
        if (!rst_n) begin
            m_pend = 1'b0; m_cq = 1'b0;
        end else begin
            bit c;
            bit clr;
            c   = exp_tx_cond();
            clr = tx_wr || (id_rd && exp_id() == 4'b0010);
            if (!c || clr) m_pend = 1'b0;
            else if (!m_cq) m_pend = 1'b1;
            m_cq = c;
        end
        @(negedge clk);
        id_rd = 1'b0;
        tx_wr = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0950));
        @(negedge clk);
        // R11: reset state
        step("R11");
        step("R11");
        rst_n = 1'b1;
        step("R11");

        // R2: zero receive trigger acts as 1
        rx_trig_reg = 7'd0; rx_level = 8'd0; step("R2");
        rx_level = 8'd1; step("R2");
        // R1: programmable receive threshold edge
        rx_trig_reg = 7'd50; rx_level = 8'd49; step("R1");
        rx_level = 8'd50; step("R1");
        // R8: receive mask
        ie_rx = 1'b0; step("R8");
        ie_rx = 1'b1; rx_level = 8'd0;

        // R3: transmit below programmable threshold
        tx_trig_reg = 7'd20; tx_level = 8'd20; step("R3");
        tx_level = 8'd19; step("R3"); step("R3");
        // R9: both pending, receive wins
        rx_level = 8'd60; step("R9");
        rx_level = 8'd0; step("R9");
        // R10: ID read of transmit source consumes it and it does not re-arm
        id_rd = 1'b1; step("R10"); step("R10"); step("R10");
        tx_level = 8'd25; step("R10");
        tx_level = 8'd3; step("R10"); step("R10");
        tx_wr = 1'b1; step("R10"); step("R10");
        // R8: transmit mask
        tx_level = 8'd30; step("R8");
        tx_level = 8'd0; ie_tx = 1'b0; step("R8"); step("R8");
        ie_tx = 1'b1; step("R8");

        // R4: zero trigger requires a quiet path
        tx_level = 8'd40; step("R4");
        tx_trig_reg = 7'd0; tx_level = 8'd0; tx_shift_empty = 1'b0; tx_line_idle = 1'b1; step("R4"); step("R4");
        tx_shift_empty = 1'b1; tx_line_idle = 1'b0; step("R4"); step("R4");
        tx_line_idle = 1'b1; step("R4"); step("R4");
        tx_level = 8'd1; step("R4");

        // R7: legacy selects ignored in enhanced mode
        rx_trig_reg = 7'd5; rx_legacy_sel = 2'd3; tx_legacy_sel = 2'd3;
        tx_trig_reg = 7'd2; tx_level = 8'd9; rx_level = 8'd5; step("R7"); step("R7");

        // R5: legacy receive table, trigger register ignored
        enh_mode = 1'b0; rx_trig_reg = 7'd1;
        rx_level = 8'd111; step("R5");
        rx_level = 8'd112; step("R5");
        rx_legacy_sel = 2'd1; rx_level = 8'd31; step("R5");
        rx_legacy_sel = 2'd2; rx_level = 8'd64; step("R5");
        rx_level = 8'd0;
        // R6: legacy transmit table, trigger register ignored
        tx_trig_reg = 7'd0; tx_legacy_sel = 2'd1; tx_level = 8'd16; step("R6");
        tx_level = 8'd15; step("R6"); step("R6");
        tx_legacy_sel = 2'd3; tx_level = 8'd64; step("R6"); step("R6");
        tx_level = 8'd63; step("R6"); step("R6");

        // Random phase with the reference model.
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 15) == 0) begin
                enh_mode      = 1'($urandom_range(0, 1));
                rx_trig_reg   = 7'($urandom_range(0, 127));
                tx_trig_reg   = ($urandom_range(0, 3) == 0) ? 7'd0 : 7'($urandom_range(0, 127));
                rx_legacy_sel = 2'($urandom_range(0, 3));
                tx_legacy_sel = 2'($urandom_range(0, 3));
                ie_rx         = ($urandom_range(0, 5) != 0);
                ie_tx         = ($urandom_range(0, 5) != 0);
            end
            rx_level       = 8'($urandom_range(0, 128));
            tx_level       = ($urandom_range(0, 3) == 0) ? 8'd0 : 8'($urandom_range(0, 128));
            tx_shift_empty = 1'($urandom_range(0, 1));
            tx_line_idle   = 1'($urandom_range(0, 1));
            id_rd          = ($urandom_range(0, 7) == 0);
            tx_wr          = ($urandom_range(0, 7) == 0);
            step("R10");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule